// File: doc/BRIEF.md
# Variable-Length Opcode Length and Jump Decoder

This block sits in the front end of a byte-stream processor. Given the byte address of the current instruction and a window of five consecutive bytes from that address, it works out how long the instruction is, where the next sequential instruction starts, and where a jump would go if the instruction were a jump. Both the length and the source of the jump displacement come from the leading bits of the opcode byte alone. Nothing else in the opcode is decoded.

The window holds the opcode in byte 0 and up to four operand bytes in bytes 1 to 4. Byte k occupies bits `8k+7:8k` of `win_i`. A displacement taken from the operand stack is supplied on a separate input. The result is registered and leaves the block one cycle after the request, together with a valid flag. Branch conditions, execution and byte fetching are handled elsewhere.

Top module: `vlop_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it goes high with no request, `out_valid`, `len_o`, `next_pc_o`, `jform_o` and `target_o` are all zero.
- R2: `len_o` depends only on opcode bits 7:5. For 000 it is 1, for 001 it is 5, for 010 and 011 it is 1, for 100 and 101 it is 2, and for 110 and 111 it is 3.
- R3: `next_pc_o` equals `pc_i + len_o` modulo 2^32.
- R4: `jform_o` encodes the displacement source. It is 0 (stack) when opcode bit 7 is 0, 1 (first operand byte) for bits 7:6 = 10, 2 (16-bit operand) for bits 7:5 = 110, and 3 (second operand byte) for bits 7:5 = 111.
- R5: In stack form, `target_o` = `pc_i + stack_off_i` modulo 2^32.
- R6: In first-byte form, `target_o` = `pc_i` plus window byte 1, taken as a signed 8-bit value.
- R7: In 16-bit form, `target_o` = `pc_i` plus the signed 16-bit value whose high byte is window byte 1 and whose low byte is window byte 2.
- R8: In second-byte form, `target_o` = `pc_i` plus window byte 2, taken as a signed 8-bit value.
- R9: `out_valid` is `in_valid` delayed by one clock, and every output reflects the request accepted on that edge.
- R10: On an edge where `in_valid` is low, `len_o`, `next_pc_o`, `jform_o` and `target_o` keep their previous values.
- R11: Window bytes 3 and 4 have no effect on any output. In the forms that do not select them, bytes 1 and 2 have no effect on the target either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| pc_i | input | 32 | Byte address of the opcode |
| win_i | input | 40 | Instruction bytes; byte 0 is the opcode |
| stack_off_i | input | 32 | Displacement from the operand stack |
| out_valid | output | 1 | Result valid, one cycle after the request |
| len_o | output | 3 | Instruction length in bytes |
| next_pc_o | output | 32 | Sequential successor address |
| jform_o | output | 2 | Displacement source code |
| target_o | output | 32 | Jump target address |

## Verification
All 256 opcode values are applied, each with operand bytes that differ from vector to vector. This separates every length class and every displacement form: a wrong bit boundary or a swapped byte gives a different length or target. The operand bytes are steered through 0x7F, 0x80, 0xFF and the 16-bit values 0x8000 and 0x7FFF, which tells sign extension apart from zero extension and shows whether the high and low bytes are swapped. Addresses close to 2^32 check that the next address and the target wrap around. Idle cycles placed between requests, and changes to bytes 3 and 4, show that the outputs hold their values and that the unused bytes have no effect.

// File: rtl/vlop_pkg.sv
package vlop_pkg;
   typedef enum logic [1:0] {
      JF_STACK = 2'd0,
      JF_BYTE1 = 2'd1,
      JF_WIDE  = 2'd2,
      JF_BYTE2 = 2'd3
   } jform_e;

   localparam int unsigned LEN_W = 3;
   localparam int unsigned OCT_W = 8;
endpackage

// File: rtl/vlop_len_dec.sv
module vlop_len_dec
   import vlop_pkg::*;
(
   input  logic [OCT_W-1:0] opc_i,
   output logic [LEN_W-1:0] len_o
);
   always_comb begin
      unique case (opc_i[OCT_W-1 -: 3])
         3'b000, 3'b010, 3'b011: len_o = LEN_W'(1);
         3'b001:                 len_o = LEN_W'(5);
         3'b100, 3'b101:         len_o = LEN_W'(2);
         default:                len_o = LEN_W'(3);
      endcase
   end
endmodule

// File: rtl/vlop_disp_sel.sv
module vlop_disp_sel
   import vlop_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [OCT_W-1:0]  opc_i,
   input  logic [OCT_W-1:0]  lit1_i,
   input  logic [OCT_W-1:0]  lit2_i,
   input  logic [ADDR_W-1:0] stack_off_i,
   output jform_e            jform_o,
   output logic [ADDR_W-1:0] disp_o
);
   localparam int unsigned EXT8  = ADDR_W - OCT_W;
   localparam int unsigned EXT16 = ADDR_W - 2*OCT_W;

   logic [ADDR_W-1:0] sx1, sx2, sx16;

   assign sx1  = {{EXT8{lit1_i[OCT_W-1]}}, lit1_i};
   assign sx2  = {{EXT8{lit2_i[OCT_W-1]}}, lit2_i};
   assign sx16 = {{EXT16{lit1_i[OCT_W-1]}}, lit1_i, lit2_i};

   always_comb begin
      if (!opc_i[OCT_W-1])
         jform_o = JF_STACK;
      else if (!opc_i[OCT_W-2])
         jform_o = JF_BYTE1;
      else if (!opc_i[OCT_W-3])
         jform_o = JF_WIDE;
      else
         jform_o = JF_BYTE2;
   end

   always_comb begin
      unique case (jform_o)
         JF_STACK: disp_o = stack_off_i;
         JF_BYTE1: disp_o = sx1;
         JF_WIDE:  disp_o = sx16;
         default:  disp_o = sx2;
      endcase
   end
endmodule

// File: rtl/vlop_decoder.sv
module vlop_decoder
   import vlop_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned WIN_BYTES = 5,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [ADDR_W-1:0]          pc_i,
   input  logic [WIN_BYTES*OCT_W-1:0] win_i,
   input  logic [ADDR_W-1:0]          stack_off_i,
   output logic                       out_valid,
   output logic [LEN_W-1:0]           len_o,
   output logic [ADDR_W-1:0]         next_pc_o,
   output logic [1:0]                 jform_o,
   output logic [ADDR_W-1:0]         target_o
);
   localparam int unsigned WIN_W = WIN_BYTES * OCT_W;

   if (ADDR_W < 2*OCT_W) begin : g_bad_addr
      $error("vlop_decoder: ADDR_W must hold a 16-bit displacement");
   end
   if (WIN_BYTES < 5) begin : g_bad_win
      $error("vlop_decoder: window must cover a five-byte instruction");
   end

   logic [OCT_W-1:0]  opc, lit1, lit2;
   logic [LEN_W-1:0]  len_c;
   jform_e            jf_c;
   logic [ADDR_W-1:0] disp_c, next_c, tgt_c;

   assign opc  = win_i[0*OCT_W +: OCT_W];
   assign lit1 = win_i[1*OCT_W +: OCT_W];
   assign lit2 = win_i[2*OCT_W +: OCT_W];

   vlop_len_dec u_len (
      .opc_i (opc),
      .len_o (len_c)
   );

   vlop_disp_sel #(.ADDR_W(ADDR_W)) u_disp (
      .opc_i       (opc),
      .lit1_i      (lit1),
      .lit2_i      (lit2),
      .stack_off_i (stack_off_i),
      .jform_o     (jf_c),
      .disp_o      (disp_c)
   );

   assign next_c = pc_i + ADDR_W'(len_c);
   assign tgt_c  = pc_i + disp_c;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            len_o     <= '0;
            next_pc_o <= '0;
            jform_o   <= '0;
            target_o  <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               len_o     <= len_c;
               next_pc_o <= next_c;
               jform_o   <= jf_c;
               target_o  <= tgt_c;
            end
         end
      end

      // R9
      valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == $past(in_valid));

      // R2
      len_five_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && (win_i[7:5] == 3'b001) |=> len_o == LEN_W'(5));

      // R3
      next_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> next_pc_o == $past(pc_i) + ADDR_W'(len_o));

      // R5
      stack_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && !win_i[7] |=>
            (jform_o == 2'd0) && (target_o == $past(pc_i + stack_off_i)));

      // R10
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(target_o) && $stable(next_pc_o)
                       && $stable(len_o) && $stable(jform_o));
   end else begin : g_comb
      assign out_valid = in_valid;
      assign len_o     = len_c;
      assign next_pc_o = next_c;
      assign jform_o   = jf_c;
      assign target_o  = tgt_c;
   end

   logic unused_ok;
   assign unused_ok = ^{win_i[WIN_W-1:3*OCT_W]};
endmodule

// File: tb/test_vlop_decoder.sv
module test_vlop_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] pc_i = '0;
   logic [39:0] win_i = '0;
   logic [31:0] stack_off_i = '0;
   logic        out_valid;
   logic [2:0]  len_o;
   logic [31:0] next_pc_o;
   logic [1:0]  jform_o;
   logic [31:0] target_o;

   int vecs = 0;
   int errs = 0;

   logic        e_valid = 1'b0;
   logic [2:0]  e_len = '0;
   logic [31:0] e_next = '0;
   logic [1:0]  e_jf = '0;
   logic [31:0] e_tgt = '0;

   always #10 clk = ~clk;

   vlop_decoder i_vlop_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_i(pc_i),
      .win_i(win_i), .stack_off_i(stack_off_i), .out_valid(out_valid),
      .len_o(len_o), .next_pc_o(next_pc_o), .jform_o(jform_o),
      .target_o(target_o)
   );

   function automatic int ref_len(int op);
      if (op < 32)       return 1;
      else if (op < 64)  return 5;
      else if (op < 128) return 1;
      else if (op < 192) return 2;
      else               return 3;
   endfunction

   function automatic int ref_form(int op);
      if (op < 128)      return 0;
      else if (op < 192) return 1;
      else if (op < 224) return 2;
      else               return 3;
   endfunction

   function automatic logic [31:0] ref_tgt(int op, logic [31:0] pc,
                                           logic [39:0] w, logic [31:0] stk);
      longint d;
      int b1, b2;
      b1 = int'(w[15:8]);
      b2 = int'(w[23:16]);
      case (ref_form(op))
         0:       d = longint'(stk);
         1:       d = (b1 >= 128) ? b1 - 256 : b1;
         2:       d = (b1 * 256 + b2 >= 32768) ? b1 * 256 + b2 - 65536 : b1 * 256 + b2;
         default: d = (b2 >= 128) ? b2 - 256 : b2;
      endcase
      return 32'(longint'(pc) + d);
   endfunction

   task automatic cmp(string tag, string what, logic [31:0] got, logic [31:0] exp);
      if (got !== exp) begin
         errs++;
         $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
      end
   endtask

   task automatic check_all(string ctx);
      string tt;
      vecs++;
      tt = (e_jf == 2'd0) ? "R5" : (e_jf == 2'd1) ? "R6" :
           (e_jf == 2'd2) ? "R7" : "R8";
      cmp(ctx == "" ? "R9" : ctx, "valid", 32'(out_valid), 32'(e_valid));
      cmp(ctx == "" ? "R2" : ctx, "len",   32'(len_o),     32'(e_len));
      cmp(ctx == "" ? "R3" : ctx, "next",  next_pc_o,      e_next);
      cmp(ctx == "" ? "R4" : ctx, "jform", 32'(jform_o),   32'(e_jf));
      cmp(ctx == "" ? tt : ctx,   "target", target_o,      e_tgt);
   endtask

   // check previous result, then apply a new request or idle cycle
   task automatic step(bit v, logic [31:0] pc, logic [39:0] w, logic [31:0] stk,
                       string ctx);
      @(negedge clk);
      check_all(ctx);
      in_valid    = v;
      pc_i        = pc;
      win_i       = w;
      stack_off_i = stk;
      e_valid     = v;
      if (v) begin
         e_len  = 3'(ref_len(int'(w[7:0])));
         e_next = pc + 32'(ref_len(int'(w[7:0])));
         e_jf   = 2'(ref_form(int'(w[7:0])));
         e_tgt  = ref_tgt(int'(w[7:0]), pc, w, stk);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      errs++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [39:0] w;
      logic [31:0] ref_t;
      // R1: outputs zero during reset
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      step(1'b0, 32'h0, 40'h0, 32'h0, "R1");

      // sweep of all opcodes, R2..R9
      for (int op = 0; op < 256; op++) begin
         w = {8'($urandom), 8'($urandom), 8'((op * 37) ^ 8'h5A),
              8'((op * 11) + 3), 8'(op)};
         step(1'b1, 32'h1000_0000 + 32'(op * 97), w,
              32'(op * 4099) - 32'h8000, "");
         if (op % 7 == 3)
            step(1'b0, 32'hDEAD_BEEF, 40'hFF_FFFF_FFFF, 32'h1234, "");
      end

      // R6 boundary bytes
      step(1'b1, 32'h100, {16'h0, 8'h00, 8'h7F, 8'h95}, 32'h0, "");
      step(1'b1, 32'h100, {16'h0, 8'h00, 8'h80, 8'h95}, 32'h0, "");
      step(1'b1, 32'h100, {16'h0, 8'h00, 8'hFF, 8'hA0}, 32'h0, "");
      // R7 16-bit extremes, high byte first
      step(1'b1, 32'h10000, {16'h0, 8'h00, 8'h80, 8'hC4}, 32'h0, "");
      step(1'b1, 32'h10000, {16'h0, 8'hFF, 8'h7F, 8'hC4}, 32'h0, "");
      step(1'b1, 32'h10000, {16'h0, 8'h01, 8'h00, 8'hC4}, 32'h0, "");
      // R8 boundary bytes
      step(1'b1, 32'h200, {16'h0, 8'h80, 8'h7F, 8'hE8}, 32'h0, "");
      step(1'b1, 32'h200, {16'h0, 8'h7F, 8'h80, 8'hE8}, 32'h0, "");
      // R3 wrap with five-byte opcode, R5 negative stack offset with wrap
      step(1'b1, 32'hFFFF_FFFE, {32'h1122_3344, 8'h20}, 32'h0, "");
      step(1'b1, 32'h0000_0004, {32'h0, 8'h05}, 32'hFFFF_FFF0, "");
      step(1'b1, 32'hFFFF_FFFF, {16'h0, 8'h00, 8'h02, 8'h90}, 32'h0, "");

      // R10: idle cycles with changed inputs hold outputs
      step(1'b1, 32'h4000, {16'h0, 8'h12, 8'h34, 8'hD0}, 32'h0, "");
      step(1'b0, 32'h9999, {16'hFFFF, 8'hFF, 8'hFF, 8'h00}, 32'h7777, "");
      step(1'b0, 32'h1, 40'h0, 32'h1, "R10");
      step(1'b0, 32'h1, 40'h0, 32'h1, "R10");

      // R11: bytes 3/4 ignored; bytes 1/2 ignored in stack form
      for (int k = 0; k < 4; k++) begin
         w = {8'(k * 77), 8'(k * 201), 8'(k * 13), 8'(k * 59), 8'hE1};
         step(1'b1, 32'h5000, w, 32'h0, "");
         @(negedge clk);
         ref_t = 32'h5000 + {{24{w[23]}}, w[23:16]};
         vecs++;
         cmp("R11", "byte2-target", target_o, ref_t);
         w = {8'(k * 31), 8'(k * 5), 8'(k * 19), 8'(k * 3), 8'h44};
         in_valid = 1'b1; pc_i = 32'h6000; win_i = w; stack_off_i = 32'h40;
         @(negedge clk);
         vecs++;
         cmp("R11", "stack-target", target_o, 32'h6040);
         in_valid = 1'b0;
         e_valid = 1'b0; e_len = 3'd1; e_next = 32'h6001; e_jf = 2'd0;
         e_tgt = 32'h6040;
      end
      step(1'b0, 32'h0, 40'h0, 32'h0, "");
      @(negedge clk);
      check_all("");
      finish_run();
   end
endmodule